// File: doc/BRIEF.md
# 2B1Q Quat Data Interface

This block carries quaternary symbols, two bits each, between a line transceiver core and a framer. There is one transmit path, from the framer pins into the core, and one receive path, from the core out to the framer pins. On the core side each path moves one quat per single-cycle strobe. On the pin side the block either drives and samples parallel quat pins or runs one serial data line per direction with a generated bit clock.

A two-bit mode input picks the transfer format at run time. The formats are parallel with the block as timing master, parallel timed by two external clocks, serial with magnitude first, and serial with sign first. The block reuses pins across modes. In the serial modes the low receive pin carries the bit clock and the high receive pin carries the data line. Only the high transmit pin is read in the serial modes. A free-running symbol clock marks symbol boundaries in every mode, and a new mode takes effect only at one of those boundaries.

Top module: `quat_if`

## Requirements
- R1: While rst_ni is low, tx_stb_o, rx_stb_o, tx_quat_o and pin_rq_o are all 0 and qclk_o is 1.
- R2: qclk_o runs in every mode with a period of SYM_DIV core cycles. It is high for the first SYM_DIV/2 cycles of each symbol and low for the rest.
- R3: In mode 00 (parallel master), rx_stb_o pulses for one cycle in the last cycle of each symbol. rx_quat_i is taken in that cycle and shown on pin_rq_o for the whole next symbol. Quat bits are {sign, magnitude}, with 10=+3, 11=+1, 01=-1, 00=-3.
- R4: In mode 00, pin_tq_i is sampled in the last cycle of a symbol. It is then presented on tx_quat_o together with a one-cycle tx_stb_o pulse in the first cycle of the next symbol.
- R5: In mode 01 (parallel slave), each rising edge of pin_tbclk_i passes through a SYNC_STAGES-flop synchroniser. Each edge gives exactly one tx_stb_o pulse, with tx_quat_o equal to the synchronised pin_tq_i. No pulse comes without an edge.
- R6: In mode 01, each rising edge of pin_rbclk_i, after synchronisation, gives exactly one rx_stb_o pulse. rx_quat_i is taken in that cycle and appears on pin_rq_o the next cycle. pin_rq_o holds its value until the next such pulse.
- R7: In modes 10 and 11, pin_rq_o[0] is the bit clock at twice the symbol rate. It is high in the first half of each bit, and its rise coincides with the rise of qclk_o.
- R8: In mode 10, the magnitude bit (quat bit 0) moves first, during the first half of the symbol, and the sign bit moves second. This holds both on pin_rq_o[1] for receive and on pin_tq_i[1] for transmit. tx_quat_o is delivered as in R4.
- R9: In mode 11, the sign bit (quat bit 1) moves first and the magnitude bit moves second, on both serial lines.
- R10: A change on mode_i is applied only at the end of a symbol. In that boundary cycle no rx_stb_o is given and no tx_stb_o follows. The receive output register, the serial shift register and the partial transmit bit are cleared to 0.
- R11: In modes 00, 10 and 11, pin_tbclk_i and pin_rbclk_i are ignored. In modes 10 and 11, pin_tq_i[0] is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Transfer format select |
| tx_quat_o | output | 2 | Quat received from framer, to core |
| tx_stb_o | output | 1 | tx_quat_o valid strobe |
| rx_quat_i | input | 2 | Quat from core, to framer |
| rx_stb_o | output | 1 | rx_quat_i taken this cycle |
| qclk_o | output | 1 | Symbol clock |
| pin_tbclk_i | input | 1 | External transmit clock (mode 01) |
| pin_rbclk_i | input | 1 | External receive clock (mode 01) |
| pin_tq_i | input | 2 | Parallel transmit quat, or [1] serial transmit data |
| pin_rq_o | output | 2 | Parallel receive quat, or {serial data, bit clock} |

## Verification
The hardest situation to reach is a mode change that lands on a symbol boundary while both directions hold live, nonzero state. The bench locks onto the rising edge of qclk_o and drives every pin at fixed offsets within a symbol. Before each switch, it leaves a nonzero receive quat loaded and a transmit quat in flight. It then raises mode_i mid-symbol and checks that the boundary drops both strobes and clears the outputs. Each master and serial mode gets an exhaustive sweep of all transmit and receive quat pairs. During these sweeps, the slave clock pins toggle in the background to show they are ignored.

// File: rtl/quat_if_pkg.sv
package quat_if_pkg;

  typedef enum logic [1:0] {
    MODE_PAR_MST = 2'b00,
    MODE_PAR_SLV = 2'b01,
    MODE_SER_MAG = 2'b10,
    MODE_SER_SGN = 2'b11
  } quat_mode_e;

  function automatic logic is_serial(quat_mode_e m);
    return m[1];
  endfunction

  // {second, first} bit order for serial receive shifting
  function automatic logic [1:0] ser_split(logic [1:0] q, logic sgn_first);
    return sgn_first ? {q[0], q[1]} : {q[1], q[0]};
  endfunction

  // rebuild {sign, mag} from serial bits in arrival order
  function automatic logic [1:0] ser_join(logic first, logic second, logic sgn_first);
    return sgn_first ? {first, second} : {second, first};
  endfunction

endpackage

// File: rtl/quat_sym_timer.sv
module quat_sym_timer
  import quat_if_pkg::*;
#(
  parameter int unsigned SYM_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  quat_mode_e mode_i,
  output quat_mode_e mode_o,
  output logic       last_o,
  output logic       bit_end_o,
  output logic       mode_chg_o,
  output logic       qclk_o,
  output logic       bclk_o
);
  localparam int unsigned CW   = (SYM_DIV > 2) ? $clog2(SYM_DIV) : 1;
  localparam int unsigned HALF = SYM_DIV / 2;
  localparam int unsigned QTR  = SYM_DIV / 4;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] bit_pos;
  quat_mode_e    mode_q;

  assign last_o     = (cnt_q == CW'(SYM_DIV - 1));
  assign bit_end_o  = (cnt_q == CW'(HALF - 1));
  assign mode_chg_o = last_o && (mode_i != mode_q);
  assign qclk_o     = (cnt_q < CW'(HALF));
  assign bit_pos    = (cnt_q >= CW'(HALF)) ? cnt_q - CW'(HALF) : cnt_q;
  assign bclk_o     = (bit_pos < CW'(QTR));
  assign mode_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_PAR_MST;
    end else begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      if (last_o) mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/quat_edge_sync.sv
module quat_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/quat_rx_path.sv
module quat_rx_path
  import quat_if_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  quat_mode_e mode_i,
  input  logic       last_i,
  input  logic       bit_end_i,
  input  logic       mode_chg_i,
  input  logic       rise_i,
  input  logic       bclk_i,
  input  logic [1:0] rx_quat_i,
  output logic       rx_stb_o,
  output logic [1:0] pin_rq_o
);
  logic       slave, serial;
  logic [1:0] rq_q;
  logic [1:0] sh_q;

  assign slave    = (mode_i == MODE_PAR_SLV);
  assign serial   = is_serial(mode_i);
  assign rx_stb_o = !mode_chg_i && (slave ? rise_i : last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_q <= '0;
      sh_q <= '0;
    end else if (mode_chg_i) begin
      rq_q <= '0;
      sh_q <= '0;
    end else begin
      if (rx_stb_o) rq_q <= rx_quat_i;
      if (serial && rx_stb_o)       sh_q <= ser_split(rx_quat_i, mode_i[0]);
      else if (serial && bit_end_i) sh_q <= {1'b0, sh_q[1]};
    end
  end

  assign pin_rq_o = serial ? {sh_q[0], bclk_i} : rq_q;
endmodule

// File: rtl/quat_tx_path.sv
module quat_tx_path
  import quat_if_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  quat_mode_e mode_i,
  input  logic       last_i,
  input  logic       bit_end_i,
  input  logic       mode_chg_i,
  input  logic       rise_i,
  input  logic [1:0] pin_tq_i,
  output logic [1:0] tx_quat_o,
  output logic       tx_stb_o
);
  logic [1:0] tq_sync_q [STAGES];
  logic       first_q;
  logic       stb_q;
  logic [1:0] quat_q;
  logic       slave, serial;

  assign slave  = (mode_i == MODE_PAR_SLV);
  assign serial = is_serial(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) tq_sync_q[s] <= '0;
    end else begin
      tq_sync_q[0] <= pin_tq_i;
      for (int s = 1; s < STAGES; s++) tq_sync_q[s] <= tq_sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      stb_q   <= 1'b0;
      quat_q  <= '0;
    end else if (mode_chg_i) begin
      first_q <= 1'b0;
      stb_q   <= 1'b0;
    end else if (slave) begin
      stb_q <= rise_i;
      if (rise_i) quat_q <= tq_sync_q[STAGES-1];
    end else begin
      if (serial && bit_end_i) first_q <= pin_tq_i[1];
      stb_q <= last_i;
      if (last_i)
        quat_q <= serial ? ser_join(first_q, pin_tq_i[1], mode_i[0]) : pin_tq_i;
    end
  end

  assign tx_stb_o  = stb_q;
  assign tx_quat_o = quat_q;
endmodule

// File: rtl/quat_if.sv
module quat_if
  import quat_if_pkg::*;
#(
  parameter int unsigned SYM_DIV     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic [1:0] tx_quat_o,
  output logic       tx_stb_o,
  input  logic [1:0] rx_quat_i,
  output logic       rx_stb_o,
  output logic       qclk_o,
  input  logic       pin_tbclk_i,
  input  logic       pin_rbclk_i,
  input  logic [1:0] pin_tq_i,
  output logic [1:0] pin_rq_o
);
  quat_mode_e mode_q;
  logic       last, bit_end, mode_chg, bclk;
  logic [1:0] ext_clk, ext_rise;

  assign ext_clk = {pin_rbclk_i, pin_tbclk_i};

  quat_sym_timer #(.SYM_DIV(SYM_DIV)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (quat_mode_e'(mode_i)),
    .mode_o     (mode_q),
    .last_o     (last),
    .bit_end_o  (bit_end),
    .mode_chg_o (mode_chg),
    .qclk_o     (qclk_o),
    .bclk_o     (bclk)
  );

  // index 0: transmit clock, index 1: receive clock
  for (genvar g = 0; g < 2; g++) begin : g_sync
    quat_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (ext_clk[g]),
      .rise_o  (ext_rise[g])
    );
  end

  quat_tx_path #(.STAGES(SYNC_STAGES)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .last_i     (last),
    .bit_end_i  (bit_end),
    .mode_chg_i (mode_chg),
    .rise_i     (ext_rise[0]),
    .pin_tq_i   (pin_tq_i),
    .tx_quat_o  (tx_quat_o),
    .tx_stb_o   (tx_stb_o)
  );

  quat_rx_path u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .last_i     (last),
    .bit_end_i  (bit_end),
    .mode_chg_i (mode_chg),
    .rise_i     (ext_rise[1]),
    .bclk_i     (bclk),
    .rx_quat_i  (rx_quat_i),
    .rx_stb_o   (rx_stb_o),
    .pin_rq_o   (pin_rq_o)
  );
endmodule

// File: rtl/quat_if_chk.sv
module quat_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_q,
  input logic       qclk_o,
  input logic       rx_stb_o,
  input logic       tx_stb_o,
  input logic [1:0] pin_rq_o
);
  assert_rx_stb_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_stb_o && mode_q != 2'b01) |=> $rose(qclk_o));

  assert_rx_hold_par_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00 && $past(mode_q) == 2'b00 && !$rose(qclk_o)) |-> $stable(pin_rq_o));

  assert_tx_stb_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_o |=> !tx_stb_o);

  assert_rx_stb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_o |=> !rx_stb_o);

  assert_rx_hold_slv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b01 && $past(mode_q) == 2'b01 && !$past(rx_stb_o)) |-> $stable(pin_rq_o));

  assert_bclk_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(qclk_o) && mode_q[1]) |-> pin_rq_o[0]);

  assert_mode_at_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> $rose(qclk_o));

  assert_no_tx_on_switch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> !tx_stb_o);
endmodule

bind quat_if quat_if_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_q   (mode_q),
  .qclk_o   (qclk_o),
  .rx_stb_o (rx_stb_o),
  .tx_stb_o (tx_stb_o),
  .pin_rq_o (pin_rq_o)
);

// File: tb/sim_quat_if.sv
module sim_quat_if;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [1:0] tx_quat_o;
  logic       tx_stb_o;
  logic [1:0] rx_quat_i = 2'b00;
  logic       rx_stb_o;
  logic       qclk_o;
  logic       pin_tbclk_i, pin_rbclk_i;
  logic [1:0] pin_tq_i = 2'b00;
  logic [1:0] pin_rq_o;

  logic tb_tog = 1'b0, rb_tog = 1'b0, tb_man = 1'b0, rb_man = 1'b0;
  bit   tog_en = 1'b0;
  bit   done = 1'b0;
  int   checks = 0, fails = 0;
  logic [1:0] cur_m = 2'b00;

  assign pin_tbclk_i = tb_tog | tb_man;
  assign pin_rbclk_i = rb_tog | rb_man;

  always #5 clk_i = ~clk_i;

  quat_if u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .tx_quat_o(tx_quat_o), .tx_stb_o(tx_stb_o),
    .rx_quat_i(rx_quat_i), .rx_stb_o(rx_stb_o), .qclk_o(qclk_o),
    .pin_tbclk_i(pin_tbclk_i), .pin_rbclk_i(pin_rbclk_i),
    .pin_tq_i(pin_tq_i), .pin_rq_o(pin_rq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // background toggling of slave clocks (R11)
  initial begin
    int n = 0;
    forever begin
      @(negedge clk_i);
      if (tog_en) begin
        n++;
        if (n % 3 == 0) tb_tog = ~tb_tog;
        if (n % 5 == 0) rb_tog = ~rb_tog;
      end else begin
        tb_tog = 1'b0;
        rb_tog = 1'b0;
      end
    end
  end

  function automatic logic first_bit(input logic [1:0] q, input logic [1:0] m);
    return (m == 2'b11) ? q[1] : q[0];
  endfunction

  function automatic logic second_bit(input logic [1:0] q, input logic [1:0] m);
    return (m == 2'b11) ? q[0] : q[1];
  endfunction

  task automatic wait_start();
    do @(negedge clk_i); while (qclk_o !== 1'b0);
    do @(negedge clk_i); while (qclk_o !== 1'b1);
  endtask

  // entered and left at the negedge of the first cycle of a symbol
  task automatic sym(input logic [1:0] qtx, input logic [1:0] qrx, input bit en,
                     input logic [1:0] pr, input logic [1:0] pt);
    bit ser;
    ser = cur_m[1];
    if (en) begin
      chk("R2 qclk high at start", qclk_o, 1);
      chk(ser ? (cur_m[0] ? "R9 tx strobe" : "R8 tx strobe") : "R4 tx strobe", tx_stb_o, 1);
      chk(ser ? (cur_m[0] ? "R9 tx quat" : "R8 tx quat") : "R4 tx quat", tx_quat_o, pt);
      if (ser) begin
        chk(cur_m[0] ? "R9 rx first bit" : "R8 rx first bit", pin_rq_o[1], first_bit(pr, cur_m));
        chk("R7 bclk high bit0", pin_rq_o[0], 1);
      end else begin
        chk("R3 rx quat on pins", pin_rq_o, pr);
      end
    end
    rx_quat_i = qrx;
    if (ser) pin_tq_i = {first_bit(qtx, cur_m), 1'($urandom)};
    else     pin_tq_i = qtx;
    @(negedge clk_i);
    if (en) begin
      chk("R11 no rx strobe mid symbol", rx_stb_o, 0);
      chk("R11 no tx strobe mid symbol", tx_stb_o, 0);
      if (ser) chk("R7 bclk low bit0", pin_rq_o[0], 0);
    end
    @(negedge clk_i);
    if (en) begin
      chk("R2 qclk low second half", qclk_o, 0);
      if (ser) begin
        chk(cur_m[0] ? "R9 rx second bit" : "R8 rx second bit", pin_rq_o[1], second_bit(pr, cur_m));
        chk("R7 bclk high bit1", pin_rq_o[0], 1);
      end
    end
    if (ser) pin_tq_i = {second_bit(qtx, cur_m), 1'($urandom)};
    @(negedge clk_i);
    chk("R3 rx strobe last cycle", rx_stb_o, 1);
    @(negedge clk_i);
  endtask

  task automatic sweep();
    logic [1:0] pr, pt;
    sym(2'd0, 2'd0, 1'b0, 2'd0, 2'd0);
    pr = 2'd0; pt = 2'd0;
    for (int i = 0; i < 16; i++) begin
      sym(i[1:0], i[3:2], 1'b1, pr, pt);
      pt = i[1:0];
      pr = i[3:2];
    end
    sym(2'd2, 2'd3, 1'b1, pr, pt);
  endtask

  task automatic switch_mode(input logic [1:0] m);
    mode_i = m;
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 no rx strobe at switch", rx_stb_o, 0);
    @(negedge clk_i);
    chk("R10 no tx strobe after switch", tx_stb_o, 0);
    if (m[1]) chk("R10 serial line cleared", pin_rq_o[1], 0);
    else      chk("R10 rx output cleared", pin_rq_o, 0);
    cur_m = m;
  endtask

  task automatic slave_tests();
    int n, hi;
    logic [1:0] got;
    for (int i = 0; i < 4; i++) begin
      pin_tq_i = i[1:0];
      repeat (2) @(negedge clk_i);
      tb_man = 1'b1;
      n = 0; got = 2'b00;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk_i);
        if (tx_stb_o) begin n++; got = tx_quat_o; end
      end
      chk("R5 one tx strobe per edge", n, 1);
      chk("R5 tx quat sampled", got, i);
      tb_man = 1'b0;
      repeat (4) @(negedge clk_i);
      rx_quat_i = 2'(3 - i);
      rb_man = 1'b1;
      n = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk_i);
        if (rx_stb_o) n++;
      end
      chk("R6 one rx strobe per edge", n, 1);
      chk("R6 rx quat on pins", pin_rq_o, 3 - i);
      rb_man = 1'b0;
      repeat (4) @(negedge clk_i);
    end
    n = 0; hi = 0;
    for (int c = 0; c < 8; c++) begin
      pin_tq_i = ~pin_tq_i;
      rx_quat_i = ~rx_quat_i;
      @(negedge clk_i);
      if (tx_stb_o || rx_stb_o) n++;
      if (qclk_o) hi++;
    end
    chk("R5 no strobe without edge", n, 0);
    chk("R6 rx pins held without edge", pin_rq_o, 0);
    chk("R2 qclk duty in slave mode", hi, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset tx_stb", tx_stb_o, 0);
    chk("R1 reset rx_stb", rx_stb_o, 0);
    chk("R1 reset tx_quat", tx_quat_o, 0);
    chk("R1 reset pin_rq", pin_rq_o, 0);
    chk("R1 reset qclk", qclk_o, 1);
    rst_ni = 1'b1;
    tog_en = 1'b1;
    wait_start();
    sweep();
    switch_mode(2'b10);
    sweep();
    switch_mode(2'b11);
    sweep();
    tog_en = 1'b0;
    switch_mode(2'b01);
    slave_tests();
    wait_start();
    switch_mode(2'b00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule